// File: doc/BRIEF.md
# SDRAM burst data-path engine

This block is the burst sequencer that sits behind the command decoder of a single-data-rate SDRAM bank group. The decoder hands it one column command per cycle: READ, WRITE, precharge (PRE) or burst stop (TBST), together with a start column. From that command the engine produces the column address of every word in the burst. It also gives a per-cycle read-access strobe and a write-access strobe, a write-capture strobe that already accounts for the data mask, and a read output-enable that follows the programmed CAS latency. A one-cycle end-of-burst flag tells auto-precharge logic where each burst finished.

The control is a three-state machine. `ST_IDLE` is the state with no burst running. `ST_RD_RUN` walks a read burst and `ST_WR_RUN` walks a write burst. A READ or WRITE in any state starts a new burst from its own column and moves to `ST_RD_RUN` or `ST_WR_RUN`, or stays in `ST_IDLE` for a one-word burst. While a burst runs, each cycle advances the word index. A burst goes back to `ST_IDLE` when its last word is accessed or when PRE or TBST arrives. Full-page bursts never reach a last word and run until a stop or a new column command.

Read words are not returned through the state machine. Each read access enters a short shift register, and the output-enable is tapped from it at the CAS latency. The tap is gated by a mask input delayed two cycles, and the deeper stages are cleared when a WRITE cuts into a read.

Top module: `sdr_burst_engine`

## Requirements
- R1: A read access in cycle n drives `rd_oe` high in cycle n+CL. CL is 2 when `cfg_cl3`=0 and 3 when `cfg_cl3`=1, so a READ with no interruption gives exactly BL consecutive `rd_oe` cycles, starting CL cycles after the command.
- R2: A WRITE command is a write access (`col_wr`=1) in its own cycle, and the following BL-1 cycles are also write accesses. The first word uses the command's column.
- R3: `cfg_bl` selects the burst length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, 3'b111 gives full page, and any other code gives 1. The setting is sampled with each READ or WRITE command.
- R4: Word i of a burst of length BL keeps the column bits above log2(BL) from the start column. The low bits are (start+i) mod BL when `cfg_ilv`=0 (sequential) and start XOR i when `cfg_ilv`=1 (interleaved).
- R5: A full-page burst always counts sequentially over the whole column space, whatever `cfg_ilv` says. It wraps from the top column to 0 and continues until PRE, TBST or a new READ/WRITE.
- R6: A READ or WRITE issued while a burst runs starts its new burst from the new column in its own cycle. Read words accessed before it still reach the bus.
- R7: `cmd_op` encodes READ=2'b00, WRITE=2'b01, PRE=2'b10, TBST=2'b11. PRE or TBST stops all column accesses from its own cycle, so `rd_oe` is low from CL cycles after it. When no burst is running, PRE or TBST changes no output.
- R8: After a WRITE command in cycle n, `rd_oe` is low in cycle n+2 and later, until a new read produces words.
- R9: During reads, `dqm` high in cycle m forces `rd_oe` low in cycle m+2.
- R10: During writes, `dqm` high in a write-access cycle drops `wr_capture` for that cycle only. The column sequence still advances past the masked word.
- R11: With `cfg_single_wr`=1 every write burst has length 1, while reads keep the programmed length.
- R12: A READ that cuts into a write burst is not a write cycle: `wr_capture` is low in the READ's cycle and after it.
- R13: `burst_end` is high in the cycle of a burst's final word when the burst reaches its length. It is also high in the cycle of a PRE/TBST that stops a running burst. A full-page burst never raises it by itself.
- R14: While `rst_n` is low, and afterwards until the first command, all strobes and `burst_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A decoded column command is present this cycle |
| cmd_op | input | 2 | Command code (READ, WRITE, PRE, TBST) |
| cmd_col | input | COL_W | Start column of a READ or WRITE |
| cfg_bl | input | 3 | Burst-length code |
| cfg_ilv | input | 1 | 1 selects interleaved ordering |
| cfg_cl3 | input | 1 | CAS latency 3 when 1, 2 when 0 |
| cfg_single_wr | input | 1 | Forces write bursts to length 1 |
| dqm | input | 1 | Data mask: write block at latency 0, read disable at latency 2 |
| col_addr | output | COL_W | Column of the word accessed this cycle |
| col_rd | output | 1 | A read word is accessed this cycle |
| col_wr | output | 1 | A write word slot occurs this cycle |
| wr_capture | output | 1 | Write data on the bus is stored this cycle |
| rd_oe | output | 1 | Read data is driven onto the bus this cycle |
| burst_end | output | 1 | A burst ends this cycle |

## Verification
The embedded properties assume that the configuration inputs stay constant while a burst or its read data is still in flight. They also assume that `cmd_op` is only meaningful while `cmd_valid` is high. The latency properties compare `rd_oe` with accesses two or three cycles earlier using the current `cfg_cl3`, so they hold only if the latency is not changed while reads are pending. The stimulus changes configuration only at the start of a scenario, after a run of idle cycles longer than the deepest latency. It never combines interleaved ordering with a full page in a way that depends on the interleaved result.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_PRE   = 2'b10,
        OP_TBST  = 2'b11
    } sdr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RD_RUN = 2'b01,
        ST_WR_RUN = 2'b10
    } sdr_state_e;

    localparam logic [2:0] BL_1    = 3'b000;
    localparam logic [2:0] BL_2    = 3'b001;
    localparam logic [2:0] BL_4    = 3'b010;
    localparam logic [2:0] BL_8    = 3'b011;
    localparam logic [2:0] BL_FULL = 3'b111;

endpackage

// File: rtl/sdr_col_order.sv
module sdr_col_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    // wrap inside the aligned block: upper bits come from the start column
    assign low_seq = start + idx;
    assign low_ilv = start ^ idx;

    always_comb begin
        addr = (start & ~mask) | ((ilv ? low_ilv : low_seq) & mask);
    end

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
    parameter int MAX_CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_access,
    input  logic wr_start,
    input  logic cl3,
    input  logic dqm,
    output logic rd_oe
);

    localparam int MASK_LAT = 2;
    localparam int KILL_FROM = 2;

    logic [MAX_CL-1:0]   stage_q;
    logic [MASK_LAT-1:0] mask_q;
    logic                kill_q;
    logic                tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
            mask_q  <= '0;
            kill_q  <= 1'b0;
        end else begin
            kill_q    <= wr_start;
            mask_q[0] <= dqm;
            for (int k = 1; k < MASK_LAT; k++) begin
                mask_q[k] <= mask_q[k-1];
            end
            stage_q[0] <= rd_access;
            for (int j = 1; j < MAX_CL; j++) begin
                // a WRITE one cycle ago removes every word that would land two or more cycles after it
                stage_q[j] <= (kill_q && j >= KILL_FROM) ? 1'b0 : stage_q[j-1];
            end
        end
    end

    generate
        if (MAX_CL >= 3) begin : g_tap
            assign tap = cl3 ? stage_q[2] : stage_q[1];
        end else begin : g_tap_cl2
            assign tap = stage_q[MAX_CL-1];
        end
    endgenerate

    assign rd_oe = tap && !mask_q[MASK_LAT-1];

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rd_oe |-> (cl3 ? $past(rd_access, 3) : $past(rd_access, 2))); // R1
    AST_RD_MASK_LAT: assert property (@(posedge clk) disable iff (!rst_n) $past(dqm, 2) |-> !rd_oe); // R9
    AST_WR_KILLS_RD: assert property (@(posedge clk) disable iff (!rst_n) $past(wr_start, 2) |-> !rd_oe); // R8

endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_burst_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MAX_CL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [COL_W-1:0] cmd_col,
    input  logic [2:0]       cfg_bl,
    input  logic             cfg_ilv,
    input  logic             cfg_cl3,
    input  logic             cfg_single_wr,
    input  logic             dqm,
    output logic [COL_W-1:0] col_addr,
    output logic             col_rd,
    output logic             col_wr,
    output logic             wr_capture,
    output logic             rd_oe,
    output logic             burst_end
);

    logic cmd_rd, cmd_wr, cmd_stop, cmd_rw;

    assign cmd_rd   = cmd_valid && (cmd_op == OP_READ);
    assign cmd_wr   = cmd_valid && (cmd_op == OP_WRITE);
    assign cmd_stop = cmd_valid && (cmd_op == OP_PRE || cmd_op == OP_TBST);
    assign cmd_rw   = cmd_rd || cmd_wr;

    sdr_state_e       state_q, state_d;
    logic [COL_W-1:0] start_q, start_d;
    logic [COL_W-1:0] idx_q, idx_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             ilv_q, ilv_d;
    logic             full_q, full_d;

    logic [COL_W-1:0] bl_mask;
    logic [COL_W-1:0] cur_start, cur_idx, cur_mask;
    logic             cur_ilv, cur_full, cur_last;

    // burst length minus one doubles as the in-block wrap mask
    always_comb begin
        case (cfg_bl)
            BL_2:    bl_mask = COL_W'(1);
            BL_4:    bl_mask = COL_W'(3);
            BL_8:    bl_mask = COL_W'(7);
            BL_FULL: bl_mask = '1;
            default: bl_mask = '0;
        endcase
    end

    // a new column command overrides the running burst in its own cycle
    always_comb begin
        if (cmd_rw) begin
            cur_start = cmd_col;
            cur_idx   = '0;
            cur_mask  = (cmd_wr && cfg_single_wr) ? '0 : bl_mask;
            cur_full  = (cfg_bl == BL_FULL) && !(cmd_wr && cfg_single_wr);
            cur_ilv   = cfg_ilv && (cfg_bl != BL_FULL);
        end else begin
            cur_start = start_q;
            cur_idx   = idx_q;
            cur_mask  = mask_q;
            cur_full  = full_q;
            cur_ilv   = ilv_q;
        end
        cur_last = !cur_full && (cur_idx == cur_mask);
    end

    sdr_col_order #(.COL_W(COL_W)) u_order (
        .start (cur_start),
        .idx   (cur_idx),
        .mask  (cur_mask),
        .ilv   (cur_ilv),
        .addr  (col_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            start_q <= '0;
            idx_q   <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= start_d;
            idx_q   <= idx_d;
            mask_q  <= mask_d;
            ilv_q   <= ilv_d;
            full_q  <= full_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        start_d = start_q;
        idx_d   = idx_q;
        mask_d  = mask_q;
        ilv_d   = ilv_q;
        full_d  = full_q;
        if (cmd_rw) begin
            start_d = cur_start;
            mask_d  = cur_mask;
            ilv_d   = cur_ilv;
            full_d  = cur_full;
            idx_d   = COL_W'(1);
            if (cur_last) state_d = ST_IDLE;
            else          state_d = cmd_rd ? ST_RD_RUN : ST_WR_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_RD_RUN, ST_WR_RUN: begin
                    if (cmd_stop || cur_last) state_d = ST_IDLE;
                    else                      idx_d   = idx_q + COL_W'(1);
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output logic
    always_comb begin
        col_rd = cmd_rd;
        col_wr = cmd_wr;
        if (!cmd_rw) begin
            unique case (state_q)
                ST_IDLE:   ;
                ST_RD_RUN: col_rd = !cmd_stop;
                ST_WR_RUN: col_wr = !cmd_stop;
                default:   ;
            endcase
        end
        wr_capture = col_wr && !dqm;
        burst_end  = ((col_rd || col_wr) && cur_last) || (cmd_stop && state_q != ST_IDLE);
    end

    sdr_rd_pipe #(.MAX_CL(MAX_CL)) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_access (col_rd),
        .wr_start  (cmd_wr),
        .cl3       (cfg_cl3),
        .dqm       (dqm),
        .rd_oe     (rd_oe)
    );

    AST_WR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == OP_WRITE && !dqm) |-> wr_capture); // R2
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op[1]) |=> ((!col_rd && !col_wr) || (cmd_valid && !cmd_op[1]))); // R7
    AST_SINGLE_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == OP_WRITE && cfg_single_wr) |-> burst_end); // R11
    AST_RD_BLOCKS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && cmd_op == OP_READ) |-> !wr_capture); // R12

endmodule

// File: tb/sdr_burst_engine_test.sv
module sdr_burst_engine_test;
    import sdr_burst_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_col = 8'h00;
    logic [2:0] cfg_bl = BL_4;
    logic       cfg_ilv = 1'b0;
    logic       cfg_cl3 = 1'b0;
    logic       cfg_single_wr = 1'b0;
    logic       dqm = 1'b0;
    logic [7:0] col_addr;
    logic       col_rd, col_wr, wr_capture, rd_oe, burst_end;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] lg_rd, lg_wr, lg_cap, lg_oe, lg_end;
    logic [7:0]  lg_addr [32];
    int          idx;

    always #5 clk = ~clk;

    sdr_burst_engine #(.COL_W(8), .MAX_CL(3)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_col(cmd_col),
        .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv), .cfg_cl3(cfg_cl3), .cfg_single_wr(cfg_single_wr),
        .dqm(dqm), .col_addr(col_addr), .col_rd(col_rd), .col_wr(col_wr),
        .wr_capture(wr_capture), .rd_oe(rd_oe), .burst_end(burst_end)
    );

    task automatic chk_vec(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_addr(input string req, input int c, input logic [7:0] exp);
        n_chk++;
        if (lg_addr[c] !== exp) begin
            n_fail++;
            $display("FAIL %s col_addr cycle %0d actual=%h expected=%h", req, c, lg_addr[c], exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [1:0] op, input logic [7:0] col, input logic m);
        cmd_valid = v; cmd_op = op; cmd_col = col; dqm = m;
        @(negedge clk);
        if (idx < 32) begin
            lg_rd[idx]   = col_rd;
            lg_wr[idx]   = col_wr;
            lg_cap[idx]  = wr_capture;
            lg_oe[idx]   = rd_oe;
            lg_end[idx]  = burst_end;
            lg_addr[idx] = col_addr;
        end
        idx++;
        @(posedge clk); #1;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 8'h00, 1'b0);
    endtask

    task automatic scn(input logic [2:0] bl, input logic ilv, input logic cl3, input logic sw);
        nop(6);
        cfg_bl = bl; cfg_ilv = ilv; cfg_cl3 = cl3; cfg_single_wr = sw;
        idx = 0;
        lg_rd = '0; lg_wr = '0; lg_cap = '0; lg_oe = '0; lg_end = '0;
    endtask

    task automatic t_read_seq_cl2();
        scn(BL_4, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_READ, 8'h06, 1'b0); nop(8);
        chk_vec("R1", "rd_oe cl2", lg_oe, 32'b111100);
        chk_vec("R3", "col_rd bl4", lg_rd, 32'b1111);
        chk_addr("R4", 0, 8'h06); chk_addr("R4", 1, 8'h07); chk_addr("R4", 2, 8'h04); chk_addr("R4", 3, 8'h05);
        chk_vec("R13", "burst_end", lg_end, 32'b1000);
    endtask

    task automatic t_read_ilv_cl3();
        scn(BL_4, 1'b1, 1'b1, 1'b0);
        cyc(1'b1, OP_READ, 8'h25, 1'b0); nop(8);
        chk_vec("R1", "rd_oe cl3", lg_oe, 32'b1111000);
        chk_addr("R4", 1, 8'h24); chk_addr("R4", 2, 8'h27); chk_addr("R4", 3, 8'h26);
    endtask

    task automatic t_write_bl8_mask();
        scn(BL_8, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_WRITE, 8'h0D, 1'b0); cyc(1'b0, 2'b00, 8'h00, 1'b0);
        cyc(1'b0, 2'b00, 8'h00, 1'b1); nop(7);
        chk_vec("R2", "col_wr", lg_wr, 32'hFF);
        chk_vec("R10", "wr_capture", lg_cap, 32'b11111011);
        chk_addr("R4", 2, 8'h0F); chk_addr("R10", 3, 8'h08); chk_addr("R4", 7, 8'h0C);
        chk_vec("R13", "burst_end bl8", lg_end, 32'h80);
    endtask

    task automatic t_bl1_read();
        scn(BL_1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_READ, 8'h33, 1'b0); nop(5);
        chk_vec("R3", "col_rd bl1", lg_rd, 32'b1);
        chk_vec("R13", "burst_end bl1", lg_end, 32'b1);
        chk_vec("R1", "rd_oe bl1", lg_oe, 32'b100);
    endtask

    task automatic t_full_page();
        scn(BL_FULL, 1'b1, 1'b0, 1'b0);
        cyc(1'b1, OP_READ, 8'hFE, 1'b0); nop(4);
        cyc(1'b1, OP_TBST, 8'h00, 1'b0); nop(5);
        chk_addr("R5", 1, 8'hFF); chk_addr("R5", 2, 8'h00); chk_addr("R5", 4, 8'h02);
        chk_vec("R7", "col_rd full", lg_rd, 32'b11111);
        chk_vec("R7", "rd_oe after tbst", lg_oe, 32'b1111100);
        chk_vec("R13", "burst_end full", lg_end, 32'b100000);
    endtask

    task automatic t_read_by_read();
        scn(BL_4, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_READ, 8'h00, 1'b0); nop(1);
        cyc(1'b1, OP_READ, 8'h20, 1'b0); nop(8);
        chk_vec("R6", "col_rd", lg_rd, 32'b111111);
        chk_addr("R6", 1, 8'h01); chk_addr("R6", 2, 8'h20); chk_addr("R6", 5, 8'h23);
        chk_vec("R6", "rd_oe", lg_oe, 32'b11111100);
        chk_vec("R13", "burst_end", lg_end, 32'b100000);
    endtask

    task automatic t_pre_cuts_read();
        scn(BL_8, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, OP_READ, 8'h00, 1'b0); nop(1);
        cyc(1'b1, OP_PRE, 8'h00, 1'b0); nop(8);
        chk_vec("R7", "col_rd", lg_rd, 32'b11);
        chk_vec("R7", "rd_oe", lg_oe, 32'b11000);
        chk_vec("R13", "burst_end", lg_end, 32'b100);
    endtask

    task automatic t_write_cuts_read();
        scn(BL_4, 1'b0, 1'b1, 1'b0);
        cyc(1'b1, OP_READ, 8'h00, 1'b0); nop(1);
        cyc(1'b1, OP_WRITE, 8'h10, 1'b0); nop(8);
        chk_vec("R8", "rd_oe", lg_oe, 32'b1000);
        chk_vec("R6", "col_rd", lg_rd, 32'b11);
        chk_vec("R2", "col_wr", lg_wr, 32'b111100);
        chk_addr("R6", 2, 8'h10);
    endtask

    task automatic t_read_mask();
        scn(BL_4, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_READ, 8'h00, 1'b0);
        cyc(1'b0, 2'b00, 8'h00, 1'b1); nop(7);
        chk_vec("R9", "rd_oe", lg_oe, 32'b110100);
    endtask

    task automatic t_single_write();
        scn(BL_4, 1'b0, 1'b0, 1'b1);
        cyc(1'b1, OP_WRITE, 8'h40, 1'b0); nop(1);
        cyc(1'b1, OP_READ, 8'h40, 1'b0); nop(8);
        chk_vec("R11", "col_wr", lg_wr, 32'b1);
        chk_vec("R11", "col_rd", lg_rd, 32'b111100);
        chk_vec("R11", "burst_end", lg_end, 32'b100001);
        chk_vec("R11", "rd_oe", lg_oe, 32'b11110000);
    endtask

    task automatic t_read_cuts_write();
        scn(BL_4, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_WRITE, 8'h30, 1'b0); nop(1);
        cyc(1'b1, OP_READ, 8'h44, 1'b0); nop(6);
        chk_vec("R12", "wr_capture", lg_cap, 32'b11);
        chk_vec("R12", "col_rd", lg_rd, 32'b111100);
        chk_addr("R12", 2, 8'h44);
    endtask

    task automatic t_stop_idle_and_write();
        scn(BL_8, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_PRE, 8'h00, 1'b0); cyc(1'b1, OP_TBST, 8'h00, 1'b0); nop(3);
        chk_vec("R7", "idle stop strobes", lg_rd | lg_wr | lg_oe | lg_end, 32'b0);
        scn(BL_8, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, OP_WRITE, 8'h50, 1'b0); nop(2);
        cyc(1'b1, OP_TBST, 8'h00, 1'b0); nop(4);
        chk_vec("R7", "col_wr after tbst", lg_wr, 32'b111);
        chk_vec("R13", "burst_end tbst", lg_end, 32'b1000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_vec("R14", "outputs in reset", {27'b0, col_rd, col_wr, wr_capture, rd_oe, burst_end}, 32'b0);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        idx = 0;
        nop(3);
        chk_vec("R14", "outputs after reset", {27'b0, col_rd, col_wr, wr_capture, rd_oe, burst_end}, 32'b0);
        t_read_seq_cl2();
        t_read_ilv_cl3();
        t_write_bl8_mask();
        t_bl1_read();
        t_full_page();
        t_read_by_read();
        t_pre_cuts_read();
        t_write_cuts_read();
        t_read_mask();
        t_single_write();
        t_read_cuts_write();
        t_stop_idle_and_write();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule